// File: doc/BRIEF.md
# Configurable-Frame Serial Receiver

This block turns an asynchronous serial line into characters. A falling edge on the idle-high line marks a possible start bit. The block confirms it halfway through that bit, then samples each following bit at its centre, using a tick that runs at sixteen times the baud rate. The frame format comes from static control inputs, which are shared with the matching transmitter: the number of data bits (5 to 8), whether a parity bit is present, and how that parity bit is judged (odd, even, forced high or forced low).

When the block samples the stop bit, it shows the received character, zero-extended to 8 bits, together with a parity-error flag and a framing-error flag. It marks them with a single-cycle valid strobe. Once a frame ends, the receiver waits until the line has been seen high before it accepts another start bit.

Top module: `uart_frame_rx`

## Requirements
- R1: Data bits arrive LSB first. `wlen_sel_i` gives 5 + wlen_sel_i data bits (0 gives 5, 3 gives 8). `data_o` holds the received bits in their low positions, and all higher bits of `data_o` are 0.
- R2: With `par_en_i` = 0 no parity bit is expected: the stop bit directly follows the last data bit, and `par_err_o` is 0 on every valid strobe.
- R3: With `par_en_i` = 1, `par_force_i` = 0 and `par_even_i` = 0 (odd format), `par_err_o` is 1 exactly when the data bits plus the parity bit hold an even number of ones.
- R4: With `par_en_i` = 1, `par_force_i` = 0 and `par_even_i` = 1 (even format), `par_err_o` is 1 exactly when the data bits plus the parity bit hold an odd number of ones.
- R5: With `par_en_i` = 1 and `par_force_i` = 1, the expected parity bit is 1 when `par_even_i` = 0 and 0 when `par_even_i` = 1. `par_err_o` is 1 exactly when the received parity bit differs from that value.
- R6: A start bit counts only if the line is still low 8 ticks after the falling edge. A low pulse shorter than that produces no valid strobe.
- R7: Only the first stop bit is checked. `frm_err_o` is 1 when it samples 0 and 0 when it samples 1.
- R8: `valid_o` is a one-cycle pulse in the cycle after the tick on which the stop bit is sampled. `data_o`, `par_err_o` and `frm_err_o` belong to that frame while `valid_o` is high. After reset, `valid_o`, `data_o` and both flags are 0.
- R9: After a frame, a line that stays low is not taken as a new start bit. A new start bit is accepted only after the line has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | One-cycle enable at 16x the baud rate |
| wlen_sel_i | input | 2 | Data bits = 5 + wlen_sel_i |
| par_en_i | input | 1 | 1: a parity bit follows the data |
| par_even_i | input | 1 | Even format, or forced-low when forced |
| par_force_i | input | 1 | 1: parity bit is compared with a fixed level |
| data_o | output | 8 | Received character, zero-extended |
| valid_o | output | 1 | One-cycle strobe for a received frame |
| par_err_o | output | 1 | Parity mismatch for this frame |
| frm_err_o | output | 1 | Stop bit sampled low |

## Verification
The assertions assume the following about the inputs:
- `tick16_i` is a single-cycle pulse separated by idle cycles.
- The control inputs do not change while a frame is in flight, because the data-bit count and the parity decision both read them live.

The stimulus respects this. It raises the tick every fourth clock, and it changes the control fields only while the line idles high for a full bit time before each start bit. The line itself changes only on bit boundaries, apart from a deliberately short low pulse that probes the start-bit check.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned WSEL_W = 2;

  typedef enum logic [2:0] {
    RX_WAIT_HI,
    RX_ARMED,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rxf_parity.sv
module rxf_parity
  import rxf_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic              pbit_i,
  input  logic              en_i,
  input  logic              even_i,
  input  logic              forced_i,
  output logic              err_o
);
  logic ones_odd;

  // data_i is zero-extended, so unused bits do not disturb the count
  assign ones_odd = (^data_i) ^ pbit_i;

  always_comb begin
    if (!en_i)         err_o = 1'b0;
    else if (forced_i) err_o = (pbit_i != ~even_i);
    else if (even_i)   err_o = ones_odd;
    else               err_o = ~ones_odd;
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              tick_i,
  input  logic [WSEL_W-1:0] wlen_sel_i,
  input  logic              par_en_i,
  input  logic              par_err_i,
  output logic [DATA_W-1:0] shift_o,
  output logic              pbit_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  localparam int unsigned CW    = $clog2(OVS);
  localparam int unsigned HALF  = OVS / 2;
  localparam int unsigned IW    = $clog2(DATA_W);
  localparam int unsigned MIN_W = DATA_W - 3;

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              pbit_q;
  logic [IW:0]       nbits;
  logic              mid_hit, full_hit, last_bit;

  assign nbits    = (IW+1)'(MIN_W) + (IW+1)'(wlen_sel_i);
  assign mid_hit  = tick_i && (cnt_q == CW'(HALF - 1));
  assign full_hit = tick_i && (cnt_q == CW'(OVS - 1));
  assign last_bit = ({1'b0, idx_q} == nbits - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_WAIT_HI;
      cnt_q     <= '0;
      idx_q     <= '0;
      shift_q   <= '0;
      pbit_q    <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i) cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        RX_WAIT_HI: if (line_i) state_q <= RX_ARMED;
        RX_ARMED: if (!line_i) begin
          state_q <= RX_START;
          cnt_q   <= '0;
          idx_q   <= '0;
          shift_q <= '0;
          pbit_q  <= 1'b0;
        end
        RX_START: if (mid_hit) begin
          cnt_q   <= '0;
          state_q <= line_i ? RX_WAIT_HI : RX_DATA;
        end
        RX_DATA: if (full_hit) begin
          cnt_q          <= '0;
          shift_q[idx_q] <= line_i;
          idx_q          <= idx_q + 1'b1;
          if (last_bit) state_q <= par_en_i ? RX_PAR : RX_STOP;
        end
        RX_PAR: if (full_hit) begin
          cnt_q   <= '0;
          pbit_q  <= line_i;
          state_q <= RX_STOP;
        end
        RX_STOP: if (full_hit) begin
          cnt_q     <= '0;
          data_o    <= shift_q;
          par_err_o <= par_err_i;
          frm_err_o <= ~line_i;
          valid_o   <= 1'b1;
          state_q   <= RX_WAIT_HI;
        end
        default: state_q <= RX_WAIT_HI;
      endcase
    end
  end

  assign shift_o = shift_q;
  assign pbit_o  = pbit_q;

  p_valid_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_valid_on_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i));
  p_idx_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_DATA) |-> ({1'b0, idx_q} < nbits));
  p_rearm_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == RX_ARMED) && ($past(state_q) == RX_WAIT_HI)) |-> $past(line_i));
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import rxf_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick16_i,
  input  logic [WSEL_W-1:0] wlen_sel_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              par_force_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  logic              line;
  logic [DATA_W-1:0] shift;
  logic              pbit, perr;

  rxf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line)
  );

  rxf_parity u_par (
    .data_i  (shift),
    .pbit_i  (pbit),
    .en_i    (par_en_i),
    .even_i  (par_even_i),
    .forced_i(par_force_i),
    .err_o   (perr)
  );

  rxf_ctrl #(.OVS(OVS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (line),
    .tick_i    (tick16_i),
    .wlen_sel_i(wlen_sel_i),
    .par_en_i  (par_en_i),
    .par_err_i (perr),
    .shift_o   (shift),
    .pbit_o    (pbit),
    .data_o    (data_o),
    .valid_o   (valid_o),
    .par_err_o (par_err_o),
    .frm_err_o (frm_err_o)
  );

  p_zero_ext_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wlen_sel_i == 2'd0) |-> (data_o[DATA_W-1:DATA_W-3] == 3'b000));
  p_no_perr_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !par_en_i) |-> !par_err_o);
endmodule

// File: tb/sim_uart_frame_rx.sv
module sim_uart_frame_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] wsel = 2'd0;
  logic       pen = 1'b0, peven = 1'b0, pforce = 1'b0;
  logic [7:0] data;
  logic       valid, perr, ferr;

  int errors = 0;
  int checks = 0;
  int rx_cnt = 0;
  logic prev_valid = 1'b0;
  logic [1:0] tdiv = 2'd0;

  typedef struct {
    logic [7:0] d;
    logic       pe;
    logic       fe;
    string      ptag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv <= 2'd0;
      tick <= 1'b0;
    end else begin
      tdiv <= tdiv + 2'd1;
      tick <= (tdiv == 2'd3);
    end
  end

  uart_frame_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick16_i(tick),
    .wlen_sel_i(wsel), .par_en_i(pen), .par_even_i(peven), .par_force_i(pforce),
    .data_o(data), .valid_o(valid), .par_err_o(perr), .frm_err_o(ferr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid) begin
      exp_t e;
      rx_cnt++;
      chk("R8 single-cycle strobe", 32'(prev_valid), 32'd0);
      if (q.size() == 0) begin
        chk("R6/R9 unexpected frame", 32'd1, 32'd0);
      end else begin
        e = q.pop_front();
        chk("R1 data", 32'(data), 32'(e.d));
        chk(e.ptag, 32'(perr), 32'(e.pe));
        chk("R7 framing", 32'(ferr), 32'(e.fe));
      end
    end
    prev_valid <= valid;
  end

  task automatic bit_time(input logic v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  // pm: 0 none, 1 odd, 2 even, 3 forced high, 4 forced low
  task automatic send_frame(input logic [7:0] d, input int wl, input int pm,
                            input bit bad_par, input logic stop_v);
    exp_t e;
    logic [7:0] dm;
    logic p;
    wsel   = 2'(wl - 5);
    pen    = (pm != 0);
    peven  = (pm == 2) || (pm == 4);
    pforce = (pm >= 3);
    bit_time(1'b1);
    dm = d & 8'((1 << wl) - 1);
    case (pm)
      1: p = ~(^dm);
      2: p = ^dm;
      3: p = 1'b1;
      default: p = 1'b0;
    endcase
    if (bad_par) p = ~p;
    e.d  = dm;
    e.pe = (pm != 0) && bad_par;
    e.fe = ~stop_v;
    case (pm)
      0: e.ptag = "R2 parity off";
      1: e.ptag = "R3 odd parity";
      2: e.ptag = "R4 even parity";
      default: e.ptag = "R5 forced parity";
    endcase
    q.push_back(e);
    bit_time(1'b0);
    for (int i = 0; i < wl; i++) bit_time(dm[i]);
    if (pm != 0) bit_time(p);
    bit_time(stop_v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    chk("R8 reset valid", 32'(valid), 32'd0);
    chk("R8 reset data", 32'(data), 32'd0);
    chk("R8 reset flags", 32'({perr, ferr}), 32'd0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    for (int wl = 5; wl <= 8; wl++)
      for (int pm = 0; pm <= 4; pm++) begin
        send_frame(8'(8'hA5 ^ (wl * 37) ^ (pm * 91)), wl, pm, 1'b0, 1'b1);
        if (pm != 0) send_frame(8'(8'h3C + wl * 13 + pm), wl, pm, 1'b1, 1'b1);
      end
    send_frame(8'hFF, 8, 0, 1'b0, 1'b1);
    send_frame(8'h00, 5, 1, 1'b0, 1'b1);

    // R7: stop bit low, line recovers at once
    send_frame(8'h5A, 8, 2, 1'b0, 1'b0);

    // R6: short low pulse (5 ticks) must be ignored
    bit_time(1'b1);
    base = rx_cnt;
    rxd = 1'b0;
    repeat (20) @(negedge clk);
    rxd = 1'b1;
    repeat (192) @(negedge clk);
    chk("R6 glitch ignored", 32'(rx_cnt - base), 32'd0);

    // R9: line stays low after a bad stop bit
    base = rx_cnt;
    send_frame(8'h96, 7, 0, 1'b0, 1'b0);
    repeat (3) bit_time(1'b0);
    bit_time(1'b1);
    chk("R9 no restart while low", 32'(rx_cnt - base), 32'd1);
    send_frame(8'hC3, 8, 4, 1'b0, 1'b1);
    bit_time(1'b1);
    chk("R9 next frame accepted", 32'(rx_cnt - base), 32'd2);

    repeat (64) @(negedge clk);
    chk("R1 scoreboard drained", 32'(q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule